// File: doc/BRIEF.md
# PS/2 Host-Side Frame Receiver

This block sits on the host side of a PS/2 link and receives the bytes a keyboard or mouse sends toward the host. The raw clock and data lines enter through a chain of synchronising flops. The clock line then passes a stable-level filter, so that short glitches are not taken as edges. On each filtered high-to-low transition of the device clock, the block samples the data line and shifts the bit into an 11-bit frame register.

Each frame carries the following bits in this order, and the block checks all of them:

- a start bit of 0;
- eight data bits, least significant bit first;
- an odd-parity bit;
- a stop bit of 1.

A clean frame produces a one-cycle valid strobe with the byte. A frame with any bad framing bit produces a one-cycle error strobe, together with flags that name the faulty bit or bits.

A watchdog counts system cycles while a frame is partly received. If the next falling edge does not arrive in time, the partial frame is discarded, so that a lost bit cannot shift every later frame out of alignment. Inhibiting the link and sending toward the device are handled elsewhere.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, rx_valid, rx_err, err_start, err_parity and err_stop are 0 and rx_byte is 0x00.
- R2: A frame whose start bit is 0, whose parity bit is correct and whose stop bit is 1 produces exactly one rx_valid pulse of one cycle, with rx_byte equal to the eight data bits. The first data bit received is rx_byte[0].
- R3: Parity is odd: the parity bit must be 1 when the data byte holds an even number of ones, and 0 otherwise. A wrong parity bit asserts err_parity and rx_err for one cycle, and no rx_valid pulse is produced for that frame.
- R4: A start bit of 1 asserts err_start and rx_err for one cycle, and no rx_valid pulse is produced for that frame.
- R5: A stop bit of 0 asserts err_stop and rx_err for one cycle, and no rx_valid pulse is produced for that frame.
- R6: rx_valid and rx_err are never high in the same cycle, and neither stays high for two consecutive cycles.
- R7: Inside a frame, if TIMEOUT_CYC system cycles pass without a falling clock edge, the bits collected so far are dropped. A complete frame that follows is decoded from its own start bit.
- R8: A low pulse on the clock line shorter than FILT_LEN system cycles is not counted as a falling edge.
- R9: rx_byte changes only in a cycle in which rx_valid or rx_err is high, and holds its value otherwise.
- R10: err_start, err_parity and err_stop are high only while rx_err is high, and rx_err is never high without at least one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clk_i | input | 1 | Device clock line level, asynchronous to clk |
| line_dat_i | input | 1 | Device data line level, asynchronous to clk |
| rx_byte | output | 8 | Data byte of the last completed frame |
| rx_valid | output | 1 | One-cycle strobe: a frame passed every check |
| rx_err | output | 1 | One-cycle strobe: a frame failed a check |
| err_start | output | 1 | Start bit was 1 (valid with rx_err) |
| err_parity | output | 1 | Parity bit was wrong (valid with rx_err) |
| err_stop | output | 1 | Stop bit was 0 (valid with rx_err) |

## Verification
The assertions check the following on every cycle:

- rx_valid and rx_err exclude each other, and each lasts a single cycle;
- the error flags agree with rx_err;
- rx_byte only moves together with a strobe.

The bench's scenarios are needed for the rest:

- that a byte is assembled least significant bit first;
- that the parity rule holds for both even and odd counts of ones;
- that each bad framing bit is reported;
- that a stale partial frame is dropped after the timeout, so the next frame decodes cleanly;
- that short glitches on the clock line leave the bit count untouched.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int BYTE_BITS  = 8;

    // Frame as it sits in the shift register once all bits are in:
    // first received bit (start) at the LSB, stop bit at the MSB.
    typedef struct packed {
        logic                 stop;
        logic                 parity;
        logic [BYTE_BITS-1:0] data;
        logic                 start;
    } frame_t;

    typedef struct packed {
        logic bad_start;
        logic bad_parity;
        logic bad_stop;
    } frame_err_t;

    // Parity bit value that makes the count of ones odd.
    function automatic logic odd_parity_bit(input logic [BYTE_BITS-1:0] d);
        return ~(^d);
    endfunction

    function automatic frame_err_t judge_frame(input frame_t f);
        frame_err_t e;
        e.bad_start  = f.start;
        e.bad_parity = (f.parity != odd_parity_bit(f.data));
        e.bad_stop   = ~f.stop;
        return e;
    endfunction

endpackage

// File: rtl/ps2rx_line_cond.sv
module ps2rx_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clk_line,
    input  logic dat_line,
    output logic fall_pulse,
    output logic dat_sync
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] c_sh;
    logic [SYNC_STAGES-1:0] d_sh;

    // Synchroniser chain, one flop pair per stage; idle level is high.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        c_sh[g] <= 1'b1;
                        d_sh[g] <= 1'b1;
                    end else begin
                        c_sh[g] <= clk_line;
                        d_sh[g] <= dat_line;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        c_sh[g] <= 1'b1;
                        d_sh[g] <= 1'b1;
                    end else begin
                        c_sh[g] <= c_sh[g-1];
                        d_sh[g] <= d_sh[g-1];
                    end
                end
            end
        end
    endgenerate

    logic          c_s;
    logic          filt_q;
    logic [CW-1:0] run_q;

    assign c_s      = c_sh[SYNC_STAGES-1];
    assign dat_sync = d_sh[SYNC_STAGES-1];

    // The filtered level follows the synchronised clock only after
    // FILT_LEN consecutive cycles of disagreement.
    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q     <= 1'b1;
            run_q      <= '0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= 1'b0;
            if (c_s != filt_q) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    filt_q     <= c_s;
                    run_q      <= '0;
                    fall_pulse <= filt_q;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/ps2rx_assembler.sv
module ps2rx_assembler
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fall,
    input  logic   dat,
    output logic   done,
    output frame_t frame
);
    localparam int IW = $clog2(FRAME_BITS + 1);
    localparam int WW = $clog2(TIMEOUT_CYC + 1);

    logic [FRAME_BITS-1:0] sh_q;
    logic [IW-1:0]         idx_q;
    logic [WW-1:0]         wd_q;

    assign frame = frame_t'(sh_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
            wd_q  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (fall) begin
                sh_q <= {dat, sh_q[FRAME_BITS-1:1]};
                wd_q <= '0;
                if (idx_q == IW'(FRAME_BITS - 1)) begin
                    idx_q <= '0;
                    done  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (idx_q != '0) begin
                // Partial frame: drop it if the next edge is too late.
                if (wd_q == WW'(TIMEOUT_CYC - 1)) begin
                    idx_q <= '0;
                    wd_q  <= '0;
                end else begin
                    wd_q <= wd_q + 1'b1;
                end
            end else begin
                wd_q <= '0;
            end
        end
    end

endmodule

// File: rtl/ps2rx_verdict.sv
module ps2rx_verdict
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  frame_t               frame,
    output logic [BYTE_BITS-1:0] byte_o,
    output logic                 valid_o,
    output logic                 err_o,
    output frame_err_t           kind_o
);
    frame_err_t e;

    assign e = judge_frame(frame);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            kind_o  <= '0;
        end else begin
            valid_o <= 1'b0;
            err_o   <= 1'b0;
            kind_o  <= '0;
            if (done) begin
                byte_o  <= frame.data;
                valid_o <= (e == '0);
                err_o   <= (e != '0);
                kind_o  <= e;
            end
        end
    end

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_clk_i,
    input  logic       line_dat_i,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_err,
    output logic       err_start,
    output logic       err_parity,
    output logic       err_stop
);
    logic       fall;
    logic       dat_s;
    logic       done;
    frame_t     frame;
    frame_err_t kind;

    ps2rx_line_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) i_cond (
        .clk       (clk),
        .rst       (rst),
        .clk_line  (line_clk_i),
        .dat_line  (line_dat_i),
        .fall_pulse(fall),
        .dat_sync  (dat_s)
    );

    ps2rx_assembler #(
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) i_asm (
        .clk  (clk),
        .rst  (rst),
        .fall (fall),
        .dat  (dat_s),
        .done (done),
        .frame(frame)
    );

    ps2rx_verdict i_verd (
        .clk    (clk),
        .rst    (rst),
        .done   (done),
        .frame  (frame),
        .byte_o (rx_byte),
        .valid_o(rx_valid),
        .err_o  (rx_err),
        .kind_o (kind)
    );

    assign err_start  = kind.bad_start;
    assign err_parity = kind.bad_parity;
    assign err_stop   = kind.bad_stop;

endmodule

// File: rtl/ps2rx_sva.sv
module ps2rx_sva (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_err,
    input logic       err_start,
    input logic       err_parity,
    input logic       err_stop
);
    // R6
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_err));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> !rx_err);

    // R10
    flag_needs_err_chk: assert property (@(posedge clk) disable iff (rst)
        (err_start || err_parity || err_stop) |-> rx_err);

    // R10
    err_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> (err_start || err_parity || err_stop));

    // R9
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid || rx_err) |-> $stable(rx_byte));

endmodule

bind ps2_frame_rx ps2rx_sva i_sva (.*);

// File: tb/test_ps2_frame_rx.sv
module test_ps2_frame_rx;

    localparam int FILT = 4;
    localparam int TOUT = 400;
    localparam int HP   = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lclk = 1'b1;
    logic       ldat = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_err, err_start, err_parity, err_stop;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int   m_valid = 0, m_err = 0, m_es = 0, m_ep = 0, m_esp = 0;
    int   m_both = 0, m_flag_noerr = 0;
    logic [7:0] m_last = 8'h00;

    always #2 clk = ~clk;

    ps2_frame_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TOUT)) i_ps2_frame_rx (
        .clk(clk), .rst(rst), .line_clk_i(lclk), .line_dat_i(ldat),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err),
        .err_start(err_start), .err_parity(err_parity), .err_stop(err_stop)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin m_valid++; m_last = rx_byte; end
            if (rx_err) m_err++;
            if (err_start) m_es++;
            if (err_parity) m_ep++;
            if (err_stop) m_esp++;
            if (rx_valid && rx_err) m_both++;
            if ((err_start || err_parity || err_stop) && !rx_err) m_flag_noerr++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic [7:0] d, input bit st,
                                       input bit pflip, input bit sp);
        return {sp, (~^d) ^ pflip, d, st};
    endfunction

    task automatic send_bits(input logic [10:0] fr, input int n);
        for (int i = 0; i < n; i++) begin
            ldat = fr[i];
            repeat (HP / 2) @(negedge clk);
            lclk = 1'b0;
            repeat (HP) @(negedge clk);
            lclk = 1'b1;
            repeat (HP / 2) @(negedge clk);
        end
        ldat = 1'b1;
    endtask

    task automatic run_frame(input logic [10:0] fr, input int ev, input int ee,
                             input int es, input int ep, input int esp,
                             input logic [7:0] eb, input string tag);
        int v0 = m_valid, e0 = m_err, s0 = m_es, p0 = m_ep, t0 = m_esp;
        send_bits(fr, 11);
        repeat (20) @(negedge clk);
        chk(m_valid - v0 == ev, {tag, " valid count"}, m_valid - v0, ev);
        chk(m_err - e0 == ee, {tag, " err count"}, m_err - e0, ee);
        chk(m_es - s0 == es, {tag, " err_start"}, m_es - s0, es);
        chk(m_ep - p0 == ep, {tag, " err_parity"}, m_ep - p0, ep);
        chk(m_esp - t0 == esp, {tag, " err_stop"}, m_esp - t0, esp);
        chk(rx_byte == eb, {tag, " byte"}, rx_byte, eb);
        if (ev == 1) chk(m_last == eb, {tag, " strobed byte"}, m_last, eb);
    endtask

    // R1
    task automatic t_reset();
        @(negedge clk);
        chk(rx_valid == 0 && rx_err == 0, "R1 strobes in reset", {rx_valid, rx_err}, 0);
        chk({err_start, err_parity, err_stop} == 0, "R1 flags in reset",
            {err_start, err_parity, err_stop}, 0);
        chk(rx_byte == 0, "R1 byte in reset", rx_byte, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rx_valid == 0 && rx_err == 0 && rx_byte == 0, "R1 after release",
            rx_byte, 0);
    endtask

    // R2, R3: good frames, both even and odd ones counts
    task automatic t_good();
        run_frame(mk(8'h15, 0, 0, 1), 1, 0, 0, 0, 0, 8'h15, "R2 byte 15");
        run_frame(mk(8'h00, 0, 0, 1), 1, 0, 0, 0, 0, 8'h00, "R3 even zero");
        run_frame(mk(8'hFF, 0, 0, 1), 1, 0, 0, 0, 0, 8'hFF, "R3 even FF");
        run_frame(mk(8'h01, 0, 0, 1), 1, 0, 0, 0, 0, 8'h01, "R2 lsb first 01");
        run_frame(mk(8'hA7, 0, 0, 1), 1, 0, 0, 0, 0, 8'hA7, "R3 odd A7");
    endtask

    task automatic t_bad_parity();
        run_frame(mk(8'h3C, 0, 1, 1), 0, 1, 0, 1, 0, 8'h3C, "R3 parity flip 3C");
        run_frame(mk(8'h07, 0, 1, 1), 0, 1, 0, 1, 0, 8'h07, "R3 parity flip 07");
    endtask

    task automatic t_bad_start();
        run_frame(mk(8'h42, 1, 0, 1), 0, 1, 1, 0, 0, 8'h42, "R4 start high");
    endtask

    task automatic t_bad_stop();
        run_frame(mk(8'h99, 0, 0, 0), 0, 1, 0, 0, 1, 8'h99, "R5 stop low");
    endtask

    // R7: stale partial frame must be dropped
    task automatic t_timeout();
        int e0 = m_err, v0 = m_valid;
        send_bits(mk(8'hFF, 0, 0, 1), 4);
        repeat (TOUT + 200) @(negedge clk);
        chk(m_err == e0 && m_valid == v0, "R7 no strobe on partial", m_err - e0, 0);
        run_frame(mk(8'h5A, 0, 0, 1), 1, 0, 0, 0, 0, 8'h5A, "R7 frame after timeout");
    endtask

    // R8: short lows on the clock line are ignored
    task automatic t_glitch();
        int e0 = m_err, v0 = m_valid;
        for (int k = 0; k < 3; k++) begin
            lclk = 1'b0;
            repeat (FILT - 2) @(negedge clk);
            lclk = 1'b1;
            repeat (10) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        chk(m_err == e0 && m_valid == v0, "R8 no strobe from glitches", m_err - e0, 0);
        run_frame(mk(8'h81, 0, 0, 1), 1, 0, 0, 0, 0, 8'h81, "R8 frame after glitches");
    endtask

    // R9: byte holds while idle
    task automatic t_hold();
        repeat (300) @(negedge clk);
        chk(rx_byte == 8'h81, "R9 byte held idle", rx_byte, 8'h81);
    endtask

    // R6, R10: cumulative monitor checks
    task automatic t_excl();
        chk(m_both == 0, "R6 valid and err together", m_both, 0);
        chk(m_flag_noerr == 0, "R10 flag without rx_err", m_flag_noerr, 0);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        repeat (10) @(negedge clk);
        t_good();
        t_bad_parity();
        t_bad_start();
        t_bad_stop();
        t_timeout();
        t_glitch();
        t_hold();
        t_excl();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
        $finish;
    end

endmodule